// File: doc/BRIEF.md
# Audio Link Controller Global Control Register

This block holds the global control word of a host audio link controller and the sequencing around it. A single 32-bit register, decoded from a simple memory-mapped bus with per-byte write enables, carries three live controls. The first is the run/reset control. The second starts a pipeline flush. The third gates whether unsolicited codec responses are passed on. The block drives the link reset pin and a synchronous reset for the rest of the controller. It runs the flush handshake with the datapath. It also stands between the bus and every other controller register, so that those registers cannot be written, and read back as defaults, while the controller is held in reset.

Entering and leaving reset are both timed sequences. The readable run bit follows the hardware, not the last value written: it changes only when a sequence completes, and a transition output is high while one is running. Link reset is held for a programmable minimum width even if software asks to leave reset too early. A flush is refused while any stream or ring is running, or while the controller is not fully operating. Completion of a flush sets a sticky flag in a small status word; software clears that flag by writing 1 to it.

Top module: `agc_global_ctl`

## Requirements
- R1: After the synchronous reset `rst`, the control word reads 0x0000_0000, `link_reset` and `core_reset` are 1, `in_transition` is 0, `flush_status` is 0, and the status word reads 0.
- R2: The control word sits at byte offset 0x08. Bit 8 is the unsolicited enable, bit 1 is the flush control, and bit 0 is the run bit. All other bits read 0 whatever was written. While the controller runs, byte lane 1 (`req_be[1]`) alone may write bit 8.
- R3: `unsol_accept` equals `unsol_valid` when bit 8 is 1, and is 0 when bit 8 is 0.
- R4: A lane-0 write of 1 to bit 0 while in reset drops `link_reset` and starts an exit sequence. During that sequence `in_transition` is 1 for exactly EXIT_CYC cycles, bit 0 reads 0, and `core_reset` stays 1. After it, bit 0 reads 1 and `core_reset` is 0.
- R5: `link_reset` stays high for at least MIN_RST_CYC consecutive cycles, even when 1 is written to bit 0 before that time. The exit sequence does not start before then.
- R6: A lane-0 write of 0 to bit 0 while running raises `link_reset` and `core_reset` in the next cycle. `in_transition` is then 1 for exactly ENTER_CYC cycles, during which bit 0 still reads 1. After that, bit 0 reads 0.
- R7: While bit 0 reads 0, a control-word write with `req_be[0]` low changes nothing.
- R8: `fwd_wr_en` is 1 for a write to an address other than the control word (0x08) and the status word (0x0C), but only while bit 0 reads 1. It is 0 in every other case.
- R9: For other addresses, `rd_data` carries `oth_rdata` while bit 0 reads 1. While bit 0 reads 0, it carries `oth_default`, unless `oth_keep` is 1, in which case it carries `oth_rdata`.
- R10: A lane-0 write with bit 1 set, made while running with all run inputs low, has two effects: `flush_start` pulses high for one cycle, and bit 1 reads 1. When `flush_done` then arrives, bit 1 returns to 0, and both `flush_status` and status bit 1 (offset 0x0C) become 1.
- R11: A flush request is refused while any `stream_run` or `ring_run` bit is 1, or while the controller is not running. A refused request gives no `flush_start`, and bit 1 stays 0.
- R12: Writing 0 to bit 1 during a flush does not end it. A `flush_done` with no flush pending does not set the status flag.
- R13: Writing 1 to status bit 1 clears the flush flag, and writing 0 leaves it. A controller reset entry also clears the flag. The flag is set only by a completed flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_be | input | 4 | Per-byte write enables |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register (combinational) |
| fwd_wr_en | output | 1 | Write strobe passed on to the other controller registers |
| oth_rdata | input | 32 | Current value of the addressed other register |
| oth_default | input | 32 | Default value of the addressed other register |
| oth_keep | input | 1 | Addressed register survives controller reset |
| link_reset | output | 1 | Link reset, active high |
| core_reset | output | 1 | Synchronous reset to the controller's internal logic |
| in_transition | output | 1 | Reset entry or exit sequence running |
| stream_run | input | NUM_STREAMS | Run flags of the streams |
| ring_run | input | 2 | Run flags of the command and response rings |
| flush_start | output | 1 | One-cycle pulse that starts a flush |
| flush_done | input | 1 | Flush completion from the datapath |
| flush_status | output | 1 | Sticky flush-complete flag |
| unsol_valid | input | 1 | Unsolicited response offered by the link |
| unsol_accept | output | 1 | Unsolicited response passed to the response ring |

## Verification
The run bit is exercised three ways: an exit requested after the minimum reset width has already passed, an entry from running, and an exit requested while link reset is still inside its minimum width. The exit and entry cycle counts are told apart from each other, and the held-off exit is told apart from an immediate one. The access gate is walked with one vector table twice, once in reset and once running. The table covers reads with and without the keep flag, writes to other registers, and reads of the control and status words, which separates the default path, the pass-through path and the local words. Flush requests are made with idle runs, with a ring running and with a stream running, and also while in reset. These are mixed with early completions and writes of 0, so that a refused request, a live flush and an ignored completion are told apart.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam int BIT_RUN   = 0;
    localparam int BIT_FLUSH = 1;
    localparam int BIT_UNSOL = 8;
    localparam int BIT_FDONE = 1;

    typedef enum logic [1:0] {
        SEQ_DOWN  = 2'd0,
        SEQ_EXIT  = 2'd1,
        SEQ_UP    = 2'd2,
        SEQ_ENTER = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic hit_ctl;
        logic hit_sts;
        logic hit_oth;
        logic wr;
        logic lane0;
        logic lane1;
        logic run_val;
        logic flush_val;
        logic unsol_val;
        logic fdone_val;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] ctl_word(input logic uen,
                                                   input logic busy,
                                                   input logic up);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_UNSOL] = uen;
        w[BIT_FLUSH] = busy;
        w[BIT_RUN]   = up;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] sts_word(input logic fdone);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_FDONE] = fdone;
        return w;
    endfunction

endpackage

// File: rtl/agc_bus_decode.sv
module agc_bus_decode
    import agc_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CTL_OFF = 8'h08,
    parameter logic [ADDR_W-1:0] STS_OFF = 8'h0C
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LANES-1:0]    req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    output bus_req_t            dec
);

    logic ctl_match;
    logic sts_match;
    logic unused_bits;

    assign ctl_match = (req_addr[ADDR_W-1:2] == CTL_OFF[ADDR_W-1:2]);
    assign sts_match = (req_addr[ADDR_W-1:2] == STS_OFF[ADDR_W-1:2]);

    always_comb begin
        dec           = '0;
        dec.hit_ctl   = ctl_match;
        dec.hit_sts   = sts_match && !ctl_match;
        dec.hit_oth   = !ctl_match && !sts_match;
        dec.wr        = req_valid && req_write;
        dec.lane0     = req_be[0];
        dec.lane1     = req_be[1];
        dec.run_val   = req_wdata[BIT_RUN];
        dec.flush_val = req_wdata[BIT_FLUSH];
        dec.unsol_val = req_wdata[BIT_UNSOL];
        dec.fdone_val = req_wdata[BIT_FDONE];
    end

    assign unused_bits = ^{req_addr[1:0], req_be[LANES-1:2],
                           req_wdata[DATA_W-1:BIT_UNSOL+1],
                           req_wdata[BIT_UNSOL-1:BIT_FLUSH+1]};

endmodule

// File: rtl/agc_rst_seq.sv
module agc_rst_seq
    import agc_pkg::*;
#(
    parameter int MIN_RST_CYC = 16,
    parameter int ENTER_CYC   = 4,
    parameter int EXIT_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_wr,
    input  logic       run_val,
    output logic       link_reset,
    output logic       core_reset,
    output logic       in_transition,
    output logic       ctrl_up,
    output logic       running
);

    localparam int MAX_SEQ = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
    localparam int SEQ_W   = $clog2(MAX_SEQ + 1);
    localparam int HOLD_W  = $clog2(MIN_RST_CYC + 1);

    seq_state_e        state_q, state_nx;
    logic              want_q, want_nx;
    logic [SEQ_W-1:0]  seq_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              hold_ok;
    logic              exit_last;
    logic              enter_last;
    logic              link_phase;

    assign want_nx    = run_wr ? run_val : want_q;
    assign hold_ok    = (hold_cnt == HOLD_W'(MIN_RST_CYC));
    assign exit_last  = (seq_cnt == SEQ_W'(EXIT_CYC - 1));
    assign enter_last = (seq_cnt == SEQ_W'(ENTER_CYC - 1));
    assign link_phase = (state_q == SEQ_DOWN) || (state_q == SEQ_ENTER);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_DOWN:  if (want_nx && hold_ok) state_nx = SEQ_EXIT;
            SEQ_EXIT: begin
                if (!want_nx)       state_nx = SEQ_ENTER;
                else if (exit_last) state_nx = SEQ_UP;
            end
            SEQ_UP:    if (!want_nx) state_nx = SEQ_ENTER;
            SEQ_ENTER: if (enter_last) state_nx = SEQ_DOWN;
            default:   state_nx = SEQ_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_DOWN;
            want_q   <= 1'b0;
            seq_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            state_q <= state_nx;
            want_q  <= want_nx;
            if (state_nx != state_q)
                seq_cnt <= '0;
            else if (state_q == SEQ_EXIT || state_q == SEQ_ENTER)
                seq_cnt <= seq_cnt + 1'b1;
            if (state_nx == SEQ_ENTER && state_q != SEQ_ENTER)
                hold_cnt <= '0;
            else if (link_phase && !hold_ok)
                hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign link_reset    = link_phase;
    assign core_reset    = (state_q != SEQ_UP);
    assign in_transition = (state_q == SEQ_EXIT) || (state_q == SEQ_ENTER);
    assign ctrl_up       = (state_q == SEQ_UP) || (state_q == SEQ_ENTER);
    assign running       = (state_q == SEQ_UP);

endmodule

// File: rtl/agc_flush_ctl.sv
module agc_flush_ctl #(
    parameter int NUM_STREAMS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   core_reset,
    input  logic                   running,
    input  logic                   flush_req,
    input  logic                   sts_clr,
    input  logic [NUM_STREAMS-1:0] stream_run,
    input  logic [1:0]             ring_run,
    input  logic                   flush_done,
    output logic                   flush_busy,
    output logic                   flush_start,
    output logic                   flush_status
);

    logic runs_idle;
    logic accept;
    logic finish;

    assign runs_idle = !(|stream_run) && !(|ring_run);
    assign accept    = flush_req && running && runs_idle && !flush_busy;
    assign finish    = flush_busy && flush_done;

    always_ff @(posedge clk) begin
        if (rst || core_reset) begin
            flush_busy   <= 1'b0;
            flush_start  <= 1'b0;
            flush_status <= 1'b0;
        end else begin
            flush_start <= accept;
            if (accept)
                flush_busy <= 1'b1;
            else if (finish)
                flush_busy <= 1'b0;
            if (finish)
                flush_status <= 1'b1;
            else if (sts_clr)
                flush_status <= 1'b0;
        end
    end

endmodule

// File: rtl/agc_access_gate.sv
module agc_access_gate
    import agc_pkg::*;
(
    input  logic              hit_ctl,
    input  logic              hit_sts,
    input  logic              hit_oth,
    input  logic              wr,
    input  logic              ctrl_up,
    input  logic [DATA_W-1:0] ctl_rd,
    input  logic [DATA_W-1:0] sts_rd,
    input  logic [DATA_W-1:0] oth_rdata,
    input  logic [DATA_W-1:0] oth_default,
    input  logic              oth_keep,
    output logic [DATA_W-1:0] rd_data,
    output logic              fwd_wr_en
);

    logic mask_oth;

    assign mask_oth  = !ctrl_up && !oth_keep;
    assign fwd_wr_en = hit_oth && wr && ctrl_up;

    always_comb begin
        if (hit_ctl)       rd_data = ctl_rd;
        else if (hit_sts)  rd_data = sts_rd;
        else if (mask_oth) rd_data = oth_default;
        else               rd_data = oth_rdata;
    end

endmodule

// File: rtl/agc_global_ctl.sv
module agc_global_ctl
    import agc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTL_OFF     = 8'h08,
    parameter logic [ADDR_W-1:0] STS_OFF     = 8'h0C,
    parameter int                NUM_STREAMS = 4,
    parameter int                MIN_RST_CYC = 16,
    parameter int                ENTER_CYC   = 4,
    parameter int                EXIT_CYC    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [3:0]             req_be,
    input  logic [31:0]            req_wdata,
    output logic [31:0]            rd_data,
    output logic                   fwd_wr_en,
    input  logic [31:0]            oth_rdata,
    input  logic [31:0]            oth_default,
    input  logic                   oth_keep,
    output logic                   link_reset,
    output logic                   core_reset,
    output logic                   in_transition,
    input  logic [NUM_STREAMS-1:0] stream_run,
    input  logic [1:0]             ring_run,
    output logic                   flush_start,
    input  logic                   flush_done,
    output logic                   flush_status,
    input  logic                   unsol_valid,
    output logic                   unsol_accept
);

    bus_req_t dec;
    logic     ctrl_up;
    logic     running;
    logic     flush_busy;
    logic     uen_q;
    logic     ctl_wr;
    logic     run_wr;
    logic     sts_clr;
    logic     uen_wr;

    agc_bus_decode #(
        .ADDR_W  (ADDR_W),
        .CTL_OFF (CTL_OFF),
        .STS_OFF (STS_OFF)
    ) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .dec       (dec)
    );

    assign ctl_wr  = dec.hit_ctl && dec.wr;
    assign run_wr  = ctl_wr && dec.lane0;
    assign uen_wr  = ctl_wr && dec.lane1 && (ctrl_up || dec.lane0);
    assign sts_clr = dec.hit_sts && dec.wr && dec.lane0 && dec.fdone_val && ctrl_up;

    agc_rst_seq #(
        .MIN_RST_CYC (MIN_RST_CYC),
        .ENTER_CYC   (ENTER_CYC),
        .EXIT_CYC    (EXIT_CYC)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .run_wr        (run_wr),
        .run_val       (dec.run_val),
        .link_reset    (link_reset),
        .core_reset    (core_reset),
        .in_transition (in_transition),
        .ctrl_up       (ctrl_up),
        .running       (running)
    );

    agc_flush_ctl #(
        .NUM_STREAMS (NUM_STREAMS)
    ) u_flush (
        .clk          (clk),
        .rst          (rst),
        .core_reset   (core_reset),
        .running      (running),
        .flush_req    (run_wr && dec.flush_val),
        .sts_clr      (sts_clr),
        .stream_run   (stream_run),
        .ring_run     (ring_run),
        .flush_done   (flush_done),
        .flush_busy   (flush_busy),
        .flush_start  (flush_start),
        .flush_status (flush_status)
    );

    always_ff @(posedge clk) begin
        if (rst)
            uen_q <= 1'b0;
        else if (uen_wr)
            uen_q <= dec.unsol_val;
    end

    assign unsol_accept = unsol_valid && uen_q;

    agc_access_gate u_gate (
        .hit_ctl     (dec.hit_ctl),
        .hit_sts     (dec.hit_sts),
        .hit_oth     (dec.hit_oth),
        .wr          (dec.wr),
        .ctrl_up     (ctrl_up),
        .ctl_rd      (ctl_word(uen_q, flush_busy, ctrl_up)),
        .sts_rd      (sts_word(flush_status)),
        .oth_rdata   (oth_rdata),
        .oth_default (oth_default),
        .oth_keep    (oth_keep),
        .rd_data     (rd_data),
        .fwd_wr_en   (fwd_wr_en)
    );

endmodule

// File: rtl/agc_global_ctl_chk.sv
module agc_global_ctl_chk #(
    parameter int MIN_RST_CYC = 16,
    parameter int NUM_STREAMS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   link_reset,
    input logic                   core_reset,
    input logic                   fwd_wr_en,
    input logic                   ctrl_up,
    input logic                   flush_start,
    input logic                   flush_done,
    input logic                   flush_status,
    input logic [NUM_STREAMS-1:0] stream_run,
    input logic [1:0]             ring_run,
    input logic                   unsol_valid,
    input logic                   unsol_accept
);

    localparam int HI_W = $clog2(MIN_RST_CYC + 2);

    logic [HI_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else if (!link_reset)
            hi_cnt <= '0;
        else if (hi_cnt != HI_W'(MIN_RST_CYC + 1))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // R5
    link_min_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_reset) |-> (hi_cnt >= HI_W'(MIN_RST_CYC)));

    // R6
    reset_pair_chk: assert property (@(posedge clk) disable iff (rst)
        link_reset |-> core_reset);

    // R8
    fwd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_wr_en |-> ctrl_up);

    // R11
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        flush_start |-> $past(!(|stream_run) && !(|ring_run) && !core_reset));

    // R13
    flush_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_status) |-> $past(flush_done));

    // R3
    unsol_gate_chk: assert property (@(posedge clk) disable iff (rst)
        unsol_accept |-> unsol_valid);

endmodule

bind agc_global_ctl agc_global_ctl_chk #(
    .MIN_RST_CYC (MIN_RST_CYC),
    .NUM_STREAMS (NUM_STREAMS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .link_reset   (link_reset),
    .core_reset   (core_reset),
    .fwd_wr_en    (fwd_wr_en),
    .ctrl_up      (ctrl_up),
    .flush_start  (flush_start),
    .flush_done   (flush_done),
    .flush_status (flush_status),
    .stream_run   (stream_run),
    .ring_run     (ring_run),
    .unsol_valid  (unsol_valid),
    .unsol_accept (unsol_accept)
);

// File: tb/agc_global_ctl_bench.sv
module agc_global_ctl_bench;

    localparam int ADDR_W = 8;
    localparam int NS     = 4;
    localparam int MIN_R  = 8;
    localparam int ENT_C  = 3;
    localparam int EXT_C  = 5;
    localparam logic [7:0] A_CTL = 8'h08;
    localparam logic [7:0] A_STS = 8'h0C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = A_CTL;
    logic [3:0]        req_be = 4'h0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rd_data;
    logic              fwd_wr_en;
    logic [31:0]       oth_rdata = '0;
    logic [31:0]       oth_default = '0;
    logic              oth_keep = 1'b0;
    logic              link_reset, core_reset, in_transition;
    logic [NS-1:0]     stream_run = '0;
    logic [1:0]        ring_run = '0;
    logic              flush_start;
    logic              flush_done = 1'b0;
    logic              flush_status;
    logic              unsol_valid = 1'b0;
    logic              unsol_accept;

    agc_global_ctl #(
        .ADDR_W(ADDR_W), .CTL_OFF(A_CTL), .STS_OFF(A_STS), .NUM_STREAMS(NS),
        .MIN_RST_CYC(MIN_R), .ENTER_CYC(ENT_C), .EXIT_CYC(EXT_C)
    ) u_agc_global_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_data(rd_data), .fwd_wr_en(fwd_wr_en), .oth_rdata(oth_rdata),
        .oth_default(oth_default), .oth_keep(oth_keep), .link_reset(link_reset),
        .core_reset(core_reset), .in_transition(in_transition),
        .stream_run(stream_run), .ring_run(ring_run), .flush_start(flush_start),
        .flush_done(flush_done), .flush_status(flush_status),
        .unsol_valid(unsol_valid), .unsol_accept(unsol_accept)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int starts = 0;
    int hi_run = 0;
    int last_hi = 0;

    typedef struct packed {
        logic [7:0]  addr;
        logic        wr;
        logic        keep;
        logic [31:0] rdat;
        logic [31:0] dflt;
        logic [31:0] exp_dn;
        logic [31:0] exp_up;
        logic        fwd_dn;
        logic        fwd_up;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h20, 1'b0, 1'b0, 32'hA5A5_0001, 32'h0000_0010, 32'h0000_0010, 32'hA5A5_0001, 1'b0, 1'b0},
        '{8'h24, 1'b0, 1'b1, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0},
        '{8'h40, 1'b1, 1'b0, 32'h0000_BEEF, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0000_BEEF, 1'b0, 1'b1},
        '{8'h44, 1'b1, 1'b1, 32'h0000_0001, 32'h0000_0002, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1},
        '{8'h0C, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{8'h08, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0}
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (flush_start) starts++;
        if (rst) hi_run = 0;
        else if (link_reset) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = A_CTL; req_be = 4'h0; req_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        req_addr = a;
        #1;
        d = rd_data;
        req_addr = A_CTL;
        #1;
    endtask

    task automatic done_pulse();
        @(negedge clk); flush_done = 1'b1;
        @(negedge clk); flush_done = 1'b0;
        #1;
    endtask

    task automatic wait_trans();
        for (int i = 0; i < 100 && !in_transition; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic walk(input logic up, input string tag);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = VECS[i].wr; req_addr = VECS[i].addr;
            req_be = 4'hF; req_wdata = '0;
            oth_rdata = VECS[i].rdat; oth_default = VECS[i].dflt; oth_keep = VECS[i].keep;
            #5;
            chk({tag, " R9 rd"}, rd_data, up ? VECS[i].exp_up : VECS[i].exp_dn);
            chk({tag, " R8 fwd"}, {31'b0, fwd_wr_en}, {31'b0, up ? VECS[i].fwd_up : VECS[i].fwd_dn});
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = A_CTL; req_be = 4'h0; oth_keep = 1'b0;
        #1;
    endtask

    initial begin
        logic [31:0] v;
        int s0, n, bad;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        rd(A_CTL, v); chk("R1 ctl", v, 32'h0);
        rd(A_STS, v); chk("R1 sts", v, 32'h0);
        chk("R1 link_reset", {31'b0, link_reset}, 32'h1);
        chk("R1 core_reset", {31'b0, core_reset}, 32'h1);
        chk("R1 in_transition", {31'b0, in_transition}, 32'h0);
        chk("R1 flush_status", {31'b0, flush_status}, 32'h0);
        unsol_valid = 1'b1; #1;
        chk("R3 unsol off", {31'b0, unsol_accept}, 32'h0);

        walk(1'b0, "reset");

        // R11 flush refused while in reset
        s0 = starts;
        wr(A_CTL, 4'b0001, 32'h2);
        @(negedge clk); #1;
        rd(A_CTL, v); chk("R11 ctl in reset", v, 32'h0);
        chk("R11 no start in reset", starts, s0);

        // R7 lane-1-only write ignored in reset
        wr(A_CTL, 4'b0010, 32'h100);
        rd(A_CTL, v); chk("R7 ctl", v, 32'h0);

        // R4 exit sequence
        wr(A_CTL, 4'b0001, 32'h1);
        wait_trans();
        n = 0; bad = 0;
        while (in_transition && n < 100) begin
            rd(A_CTL, v);
            if (v[0] !== 1'b0 || link_reset !== 1'b0 || core_reset !== 1'b1) bad++;
            n++;
            @(negedge clk); #1;
        end
        chk("R4 exit length", n, EXT_C);
        chk("R4 exit outputs", bad, 0);
        rd(A_CTL, v); chk("R4 ctl up", v, 32'h1);
        chk("R4 core_reset low", {31'b0, core_reset}, 32'h0);
        chk("R5 first width", {31'b0, last_hi >= MIN_R}, 32'h1);

        walk(1'b1, "run");

        // R2 reserved bits and R11 stream refusal
        stream_run = 4'b0001;
        s0 = starts;
        wr(A_CTL, 4'hF, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        rd(A_CTL, v); chk("R2 reserved zero", v, 32'h101);
        chk("R11 stream refuse", starts, s0);
        stream_run = '0;
        wr(A_CTL, 4'b0011, 32'h1);
        rd(A_CTL, v); chk("R2 clear bit8", v, 32'h1);
        chk("R3 unsol dropped", {31'b0, unsol_accept}, 32'h0);
        wr(A_CTL, 4'b0010, 32'h100);
        rd(A_CTL, v); chk("R2 lane1 write", v, 32'h101);
        chk("R3 unsol accepted", {31'b0, unsol_accept}, 32'h1);
        unsol_valid = 1'b0; #1;
        chk("R3 no valid", {31'b0, unsol_accept}, 32'h0);

        // R10 flush
        s0 = starts;
        wr(A_CTL, 4'b0001, 32'h3);
        chk("R10 start pulse", {31'b0, flush_start}, 32'h1);
        rd(A_CTL, v); chk("R10 busy", v, 32'h103);
        @(negedge clk); #1;
        chk("R10 pulse one cycle", {31'b0, flush_start}, 32'h0);
        // R12 writing 0 to bit 1 during flush
        wr(A_CTL, 4'b0001, 32'h1);
        rd(A_CTL, v); chk("R12 still busy", v, 32'h103);
        chk("R10 one start", starts, s0 + 1);
        done_pulse();
        rd(A_CTL, v); chk("R10 done clears", v, 32'h101);
        chk("R10 flag", {31'b0, flush_status}, 32'h1);
        rd(A_STS, v); chk("R10 sts bit1", v, 32'h2);
        // R13 clear semantics
        wr(A_STS, 4'b0001, 32'h0);
        rd(A_STS, v); chk("R13 write0 keeps", v, 32'h2);
        wr(A_STS, 4'b0001, 32'h2);
        rd(A_STS, v); chk("R13 write1 clears", v, 32'h0);
        // R12 completion without flush
        done_pulse();
        rd(A_STS, v); chk("R12 stray done", v, 32'h0);

        // R11 ring and stream refusals
        ring_run = 2'b01;
        s0 = starts;
        wr(A_CTL, 4'b0001, 32'h3);
        @(negedge clk); #1;
        rd(A_CTL, v); chk("R11 ring refuse", v, 32'h101);
        ring_run = '0; stream_run = 4'b1000;
        wr(A_CTL, 4'b0001, 32'h3);
        @(negedge clk); #1;
        rd(A_CTL, v); chk("R11 stream3 refuse", v, 32'h101);
        chk("R11 no starts", starts, s0);
        stream_run = '0;

        // R13 reset entry clears the flag; R6 entry sequence
        wr(A_CTL, 4'b0001, 32'h3);
        done_pulse();
        chk("R13 flag set again", {31'b0, flush_status}, 32'h1);
        wr(A_CTL, 4'b0001, 32'h0);
        chk("R6 link_reset", {31'b0, link_reset}, 32'h1);
        chk("R6 core_reset", {31'b0, core_reset}, 32'h1);
        n = 0; bad = 0;
        while (in_transition && n < 100) begin
            rd(A_CTL, v);
            if (v[0] !== 1'b1 || link_reset !== 1'b1) bad++;
            n++;
            @(negedge clk); #1;
        end
        chk("R6 enter length", n, ENT_C);
        chk("R6 bit0 held", bad, 0);
        rd(A_CTL, v); chk("R6 ctl down", v, 32'h100);
        chk("R13 cleared by reset", {31'b0, flush_status}, 32'h0);

        // R5 early exit request held off
        wr(A_CTL, 4'b0001, 32'h1);
        chk("R5 held link", {31'b0, link_reset}, 32'h1);
        chk("R5 held no exit", {31'b0, in_transition}, 32'h0);
        wait_trans();
        chk("R5 width", {31'b0, last_hi >= MIN_R}, 32'h1);
        n = 0;
        while (in_transition && n < 100) begin
            n++;
            @(negedge clk); #1;
        end
        chk("R4 second exit length", n, EXT_C);
        rd(A_CTL, v); chk("R4 up again", v, 32'h101);

        summary();
        $finish;
    end

endmodule